// File: doc/BRIEF.md
# Serial Synthesizer Programming Register

This block takes configuration words for a frequency synthesizer over a three-wire serial port. The wires are a serial clock, a data line and a load strobe. All three are asynchronous to the system clock. They pass through synchronizers, and edges are detected in the system clock domain.

Each rising edge of the serial clock shifts one data bit into a 19-bit register, most significant bit first. A rising edge of the load strobe then copies the register into one of two holding latches. The last bit shifted in picks the latch:

- The feedback latch takes an 11-bit main divide value and a 7-bit swallow count.
- The reference latch takes a 14-bit reference divide value and a prescaler-select bit.

A setting that breaks the range rules is refused: the latch keeps its last legal contents, and a sticky error flag for that latch is raised. The outputs are plain levels. There is no stream interface, so there is no valid/ready handshake and no back-pressure; a word may be sent at any time.

Top module: `ser_synth_cfg`

## Requirements
- R1: After reset the outputs read main divide 16, swallow 0, reference 8, prescaler select 0 (select 0 means modulus 32, select 1 means modulus 64), and both error flags 0.
- R2: Data is sampled on each rising edge of the serial clock and shifted in MSB first. Only the last 19 bits before the load strobe count; earlier bits are shifted out and lost.
- R3: When the last bit is 0, the load copies the first 11 bits of the word (word bits 18..8, MSB first) to the main divide output and the next 7 bits (word bits 7..1) to the swallow output.
- R4: When the last bit is 1, the load copies word bit 15 to prescaler select and word bits 14..1 to the reference output. Word bits 18..16 are ignored, so a 16-bit word is enough.
- R5: The latch not picked by the last bit keeps its contents through a load.
- R6: A feedback load with main divide below 16 leaves the feedback latch unchanged and sets the feedback error flag.
- R7: A feedback load with swallow greater than or equal to main divide leaves the feedback latch unchanged and sets the feedback error flag.
- R8: A reference load with reference divide below 8 leaves the reference latch unchanged and sets the reference error flag.
- R9: Error flags are sticky. A later legal load updates its latch, but the flag stays 1 until reset.
- R10: Shifting bits without a rising edge of the load strobe changes no output.
- R11: The limit values are accepted: main 16 with swallow 15, main 2047 with swallow 127, reference 8, and reference 16383.
- R12: If a serial clock rise and a load rise are seen in the same system cycle, the load takes the register as it was before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data line (asynchronous) |
| ser_le_i | input | 1 | Load strobe, acts on its rising edge (asynchronous) |
| n_o | output | 11 | Latched main divide value |
| a_o | output | 7 | Latched swallow count |
| r_o | output | 14 | Latched reference divide value |
| psel_o | output | 1 | Latched prescaler select (0 = 32, 1 = 64) |
| div_err_o | output | 1 | Sticky feedback-latch error flag |
| ref_err_o | output | 1 | Sticky reference-latch error flag |

## Verification
A shift and a load can happen in the same system cycle: both raw pins rise at the same instant, so the synchronizers pass both edges out together. The bench provokes this by shifting a complete word without a load. It then raises the serial clock and the load strobe on the same edge, with a different data bit on the line. The check passes only if the latched fields decode the complete word and not the word shifted one place further. A design that lets the new bit reach the latch is caught by this check.

// File: rtl/ser_synth_cfg_pkg.sv
package ser_synth_cfg_pkg;
  localparam int unsigned N_W_DEF   = 11;
  localparam int unsigned A_W_DEF   = 7;
  localparam int unsigned R_W_DEF   = 14;
  localparam int unsigned N_MIN_DEF = 16;
  localparam int unsigned R_MIN_DEF = 8;

  typedef enum logic {
    SEL_FEEDBACK  = 1'b0,
    SEL_REFERENCE = 1'b1
  } latch_sel_e;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[s] <= '0;
        else if (s == 0) q[s] <= async_i;
        else q[s] <= q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], din_i};
  end
endmodule

// File: rtl/ssc_fb_latch.sv
module ssc_fb_latch #(
  parameter int unsigned N_W   = 11,
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_MIN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [N_W+A_W-1:0] payload_i,
  output logic [N_W-1:0] n_o,
  output logic [A_W-1:0] a_o,
  output logic           err_o
);
  logic [N_W-1:0] n_new;
  logic [A_W-1:0] a_new;
  logic           legal;

  assign n_new = payload_i[N_W+A_W-1:A_W];
  assign a_new = payload_i[A_W-1:0];
  // swallow count must be strictly smaller than main divide
  assign legal = (n_new >= N_W'(N_MIN)) && (32'(a_new) < 32'(n_new));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_o   <= N_W'(N_MIN);
      a_o   <= '0;
      err_o <= 1'b0;
    end else if (load_i) begin
      if (legal) begin
        n_o <= n_new;
        a_o <= a_new;
      end else begin
        err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssc_ref_latch.sv
module ssc_ref_latch #(
  parameter int unsigned R_W   = 14,
  parameter int unsigned R_MIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [R_W:0]   payload_i,
  output logic [R_W-1:0] r_o,
  output logic           psel_o,
  output logic           err_o
);
  logic legal;
  assign legal = payload_i[R_W-1:0] >= R_W'(R_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_o    <= R_W'(R_MIN);
      psel_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (load_i) begin
      if (legal) begin
        r_o    <= payload_i[R_W-1:0];
        psel_o <= payload_i[R_W];
      end else begin
        err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_synth_cfg.sv
module ser_synth_cfg
  import ser_synth_cfg_pkg::*;
#(
  parameter int unsigned N_W         = N_W_DEF,
  parameter int unsigned A_W         = A_W_DEF,
  parameter int unsigned R_W         = R_W_DEF,
  parameter int unsigned N_MIN       = N_MIN_DEF,
  parameter int unsigned R_MIN       = R_MIN_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_le_i,
  output logic [N_W-1:0] n_o,
  output logic [A_W-1:0] a_o,
  output logic [R_W-1:0] r_o,
  output logic           psel_o,
  output logic           div_err_o,
  output logic           ref_err_o
);
  localparam int unsigned PAY_W  = N_W + A_W;
  localparam int unsigned WORD_W = PAY_W + 1;

  logic [2:0]        pins_sync;
  logic              sclk_q, le_q;
  logic              sclk_rise, le_rise;
  logic [WORD_W-1:0] word;
  latch_sel_e        ctrl_bit;
  logic              load_fb, load_ref;

  ssc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ser_le_i, ser_data_i, ser_clk_i}),
    .sync_o (pins_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= pins_sync[0];
      le_q   <= pins_sync[2];
    end
  end

  assign sclk_rise = pins_sync[0] & ~sclk_q;
  assign le_rise   = pins_sync[2] & ~le_q;

  ssc_shifter #(.W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift_i(sclk_rise),
    .din_i  (pins_sync[1]),
    .word_o (word)
  );

  // last bit in steers the load; the register is read before any same-cycle shift
  assign ctrl_bit = latch_sel_e'(word[0]);
  assign load_fb  = le_rise && (ctrl_bit == SEL_FEEDBACK);
  assign load_ref = le_rise && (ctrl_bit == SEL_REFERENCE);

  ssc_fb_latch #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_fb (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_fb),
    .payload_i(word[WORD_W-1:1]),
    .n_o      (n_o),
    .a_o      (a_o),
    .err_o    (div_err_o)
  );

  ssc_ref_latch #(.R_W(R_W), .R_MIN(R_MIN)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_ref),
    .payload_i(word[R_W+1:1]),
    .r_o      (r_o),
    .psel_o   (psel_o),
    .err_o    (ref_err_o)
  );
endmodule

// File: rtl/ser_synth_cfg_chk.sv
module ser_synth_cfg_chk #(
  parameter int unsigned N_W   = 11,
  parameter int unsigned A_W   = 7,
  parameter int unsigned R_W   = 14,
  parameter int unsigned N_MIN = 16,
  parameter int unsigned R_MIN = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           le_rise,
  input logic           sel,
  input logic [N_W-1:0] n_o,
  input logic [A_W-1:0] a_o,
  input logic [R_W-1:0] r_o,
  input logic           psel_o,
  input logic           div_err_o,
  input logic           ref_err_o
);
  // R6 R7: the feedback latch never holds an illegal pair
  assert_fb_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (n_o >= N_W'(N_MIN)) && (32'(a_o) < 32'(n_o)));
  // R8: the reference latch never holds an illegal value
  assert_ref_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    r_o >= R_W'(R_MIN));
  // R9: error flags never fall while out of reset
  assert_div_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_err_o |=> div_err_o);
  assert_ref_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err_o |=> ref_err_o);
  // R10: without a load edge nothing latched moves
  assert_hold_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(n_o) && $stable(a_o) && $stable(r_o) && $stable(psel_o));
  // R5: the latch not picked keeps its contents
  assert_ref_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !sel) |=> $stable(r_o) && $stable(psel_o) && $stable(ref_err_o));
  assert_fb_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sel) |=> $stable(n_o) && $stable(a_o) && $stable(div_err_o));
endmodule

bind ser_synth_cfg ser_synth_cfg_chk #(
  .N_W(N_W), .A_W(A_W), .R_W(R_W), .N_MIN(N_MIN), .R_MIN(R_MIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .le_rise  (le_rise),
  .sel      (word[0]),
  .n_o      (n_o),
  .a_o      (a_o),
  .r_o      (r_o),
  .psel_o   (psel_o),
  .div_err_o(div_err_o),
  .ref_err_o(ref_err_o)
);

// File: tb/ser_synth_cfg_tb_top.sv
module ser_synth_cfg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [10:0] n_o;
  logic [6:0]  a_o;
  logic [13:0] r_o;
  logic psel_o, div_err_o, ref_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_synth_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_le_i(ser_le), .n_o(n_o), .a_o(a_o), .r_o(r_o), .psel_o(psel_o),
    .div_err_o(div_err_o), .ref_err_o(ref_err_o)
  );

  typedef struct {
    logic [10:0] n; logic [6:0] a; logic [13:0] r;
    logic ps; logic de; logic re; string tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t model;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [18:0] fb_word(int n, int a);
    return {11'(n), 7'(a), 1'b0};
  endfunction
  function automatic logic [18:0] ref_word(logic ps, int r, logic [2:0] junk);
    return {junk, ps, 14'(r), 1'b1};
  endfunction

  // expected-state model built from the requirements
  function automatic void model_load(logic [18:0] w);
    if (w[0] == 1'b0) begin
      if (w[18:8] < 16 || {4'b0, w[7:1]} >= w[18:8]) model.de = 1'b1;
      else begin model.n = w[18:8]; model.a = w[7:1]; end
    end else begin
      if (w[14:1] < 8) model.re = 1'b1;
      else begin model.r = w[14:1]; model.ps = w[15]; end
    end
  endfunction

  function automatic void model_reset();
    model.n = 11'd16; model.a = '0; model.r = 14'd8;
    model.ps = 1'b0; model.de = 1'b0; model.re = 1'b0;
  endfunction

  task automatic push(string tag);
    exp_t e;
    repeat (8) @(negedge clk);
    e = model; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic shift_bit(logic b);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic shift_bits(logic [31:0] v, int len);
    for (int i = len - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic pulse_le();
    repeat (4) @(negedge clk);
    ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
  endtask

  task automatic send(logic [18:0] w, string tag);
    shift_bits({13'b0, w}, 19);
    pulse_le();
    model_load(w);
    push(tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    push(tag);
  endtask

  // monitor: pop and compare against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (n_o !== e.n || a_o !== e.a || r_o !== e.r || psel_o !== e.ps ||
            div_err_o !== e.de || ref_err_o !== e.re) begin
          n_fail++;
          $display("FAIL %s: got n=%0d a=%0d r=%0d ps=%0b de=%0b re=%0b exp n=%0d a=%0d r=%0d ps=%0b de=%0b re=%0b",
                   e.tag, n_o, a_o, r_o, psel_o, div_err_o, ref_err_o,
                   e.n, e.a, e.r, e.ps, e.de, e.re);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push("R1 reset state");
    send(fb_word(1000, 100), "R3 feedback load");
    send(ref_word(1'b1, 5000, 3'b101), "R4 R5 reference load, junk bits ignored");
    send(fb_word(300, 7), "R3 R5 feedback load keeps reference");
    // R10: shift a full word with no load edge
    shift_bits({13'b0, fb_word(50, 3)}, 19);
    push("R10 shifting alone changes nothing");
    // R2: leading extra bits are shifted out
    shift_bits(32'h0000_000B, 4);
    send(fb_word(2047, 127), "R2 R11 last 19 bits only, upper limits");
    send(fb_word(20, 20), "R7 swallow equal to main refused");
    send(fb_word(16, 15), "R9 R11 legal after error, flag sticky");
    do_reset("R1 reset clears flags");
    send(fb_word(15, 0), "R6 main below minimum refused");
    send(ref_word(1'b0, 7, 3'b000), "R8 reference below minimum refused");
    send(ref_word(1'b0, 8, 3'b111), "R9 R11 reference minimum accepted");
    send(ref_word(1'b1, 16383, 3'b000), "R11 reference maximum");
    // R12: serial clock and load rise together
    shift_bits({13'b0, fb_word(600, 55)}, 19);
    @(negedge clk) ser_data = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1; ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0; ser_le = 1'b0;
    model_load(fb_word(600, 55));
    push("R12 same-cycle shift and load uses pre-shift word");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule